// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block is the byte-wide programming front end of a four-channel DMA controller. Software reaches it through a small window of register offsets. The lower half of the window reaches each channel's 16-bit address and count registers. The upper half reaches the controller-wide registers: command, request/status, mask, mode and a few one-shot strobes. A single shared byte-pointer flip-flop decides whether an address or count access touches the low or the high byte. Software therefore writes or reads every 16-bit value as two consecutive byte accesses.

The transfer engine, which is a separate block, reads the programmed state straight from the output ports. These ports carry the base and current values, the per-channel mode, the mask bits, the request bits and the controller disable. The engine reports progress back through a count-load input and terminal-count pulses. Peripheral request lines are sampled each cycle into the status register. A parameter selects a word-spaced variant, in which the incoming port offset is shifted right by one before it is decoded.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, the command register reads 0x00, status reads 0x00, the mask register reads 0x0F, and every channel's base and current registers are zero.
- R2: Every access at offsets 0-7, read or write, uses the byte pointer and then toggles it: 0 selects the low byte and 1 selects the high byte. A write at offset 12 clears the pointer. A read at offset 12 or offset 11 sets it.
- R3: Offsets 0-7 select channel = offset>>1, with offset bit 0 choosing count (1) or address (0). A low-byte write changes only the low byte of the base register. A high-byte write loads the high byte of the base, clears the channel's current count and copies the base address into the current address.
- R4: A count read returns base count minus current count. An address read returns current address plus current count, or minus current count when mode bit 5 is set.
- R5: A status read (offset 8) returns {request[3:0], tc[3:0]} and then clears the tc bits. A tc pulse from the engine in the same cycle as the read still sets its bit.
- R6: A request write (offset 9) takes the channel from bits 1:0 and the new request value from bit 2, and clears that channel's tc bit. A request read (offset 9) returns {4'hF, request[3:0]}.
- R7: On each cycle without a request write, each request bit follows its DREQ input level. A request write to a channel overrides that channel's DREQ for that cycle.
- R8: A single-mask write (offset 10) sets mask[bits 1:0] to bit 2. A write at offset 14 clears all mask bits. A write at offset 15 loads mask[3:0] from data bits 3:0. A read at offset 15 returns the mask zero-extended.
- R9: A mode write (offset 11) stores the full byte into the channel given by bits 1:0. A mode read returns the mode of the channel selected by a 2-bit read counter, with bits 1:0 forced to 1, and then increments the counter. A read at offset 14 resets the counter to 0.
- R10: A command write (offset 8) is ignored when any of data bits 0, 1, 3, 5, 6 or 7 is set. Otherwise it loads the command, and command bit 2 drives the controller-disable output. A read at offset 10 returns the command.
- R11: A master clear (write at offset 13) zeroes command, status, mode read counter and byte pointer, and sets all mask bits. Base and current registers keep their values.
- R12: With WORD_MODE=1 the port offset is one bit wider and is shifted right by one before decoding, so ports 2k and 2k+1 reach the same register.
- R13: Read data is registered: it updates on the clock edge that samples a read and holds otherwise. Reads at offsets 12, 13 and 14 return 0. When read and write strobes coincide, only the write takes effect and read data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_ofs | input | 4+WORD_MODE | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| dreq | input | 4 | Per-channel request levels |
| tc_set | input | 4 | Terminal-count pulses from the engine |
| eng_cnt_we | input | 1 | Engine load of a current count |
| eng_cnt_ch | input | 2 | Channel for the engine load |
| eng_cnt_val | input | 16 | Current count value from the engine |
| rd_data | output | 8 | Registered read data |
| base_addr_o | output | 64 | Base address, 16 bits per channel |
| cur_addr_o | output | 64 | Current address, 16 bits per channel |
| base_cnt_o | output | 64 | Base count, 16 bits per channel |
| cur_cnt_o | output | 64 | Current count, 16 bits per channel |
| mode_o | output | 32 | Mode byte per channel |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Request bits |
| ctrl_off_o | output | 1 | Controller disable (command bit 2) |

## Verification
Several behaviours are checked by assertions on every cycle. These are the rebasing of current values after a high-byte write, the toggling of the byte pointer on each address or count access, and the rejection of unsupported command writes. The assertions also cover the clearing of tc after a status read, the tracking of DREQ by the request bits, the master-clear state, and the holding of read data when no read happens. Only the bench scenarios can show the actual byte values returned by readback. These include the decrement-direction arithmetic, the mode read counter's walk across channels, override priorities that fall in the same cycle, and the word-spaced decoding of the alternate variant.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // controller-register selectors (offset bits 2:0 when offset bit 3 is set)
  localparam logic [2:0] CW_CMD     = 3'd0;
  localparam logic [2:0] CW_REQ     = 3'd1;
  localparam logic [2:0] CW_MASK1   = 3'd2;
  localparam logic [2:0] CW_MODE    = 3'd3;
  localparam logic [2:0] CW_BPCLR   = 3'd4;
  localparam logic [2:0] CW_MCLR    = 3'd5;
  localparam logic [2:0] CW_MASKCLR = 3'd6;
  localparam logic [2:0] CW_MASKALL = 3'd7;

  localparam logic [2:0] CR_STAT    = 3'd0;
  localparam logic [2:0] CR_REQ     = 3'd1;
  localparam logic [2:0] CR_CMD     = 3'd2;
  localparam logic [2:0] CR_MODE    = 3'd3;
  localparam logic [2:0] CR_BPSET   = 3'd4;
  localparam logic [2:0] CR_TEMP    = 3'd5;
  localparam logic [2:0] CR_MCNT    = 3'd6;
  localparam logic [2:0] CR_MASK    = 3'd7;

  // command bits that make a command write void
  localparam logic [7:0] CMD_REJECT = 8'hEB;
  localparam int         CMD_OFF_BIT = 2;
  localparam int         MODE_DEC_BIT = 5;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int BYTE_W = 8,
  localparam int REG_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_cnt,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mode_we,
  input  logic [BYTE_W-1:0] mode_in,
  input  logic              eng_we,
  input  logic [REG_W-1:0]  eng_cnt,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output logic [BYTE_W-1:0] mode,
  output logic [REG_W-1:0]  rb_addr,
  output logic [REG_W-1:0]  rb_cnt
);
  import dmac_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
    end else begin
      if (wr_lo) begin
        if (wr_cnt) base_cnt[BYTE_W-1:0]  <= wdata;
        else        base_addr[BYTE_W-1:0] <= wdata;
      end
      if (wr_hi) begin
        if (wr_cnt) begin
          base_cnt[REG_W-1:BYTE_W] <= wdata;
          cur_addr <= base_addr;
        end else begin
          base_addr[REG_W-1:BYTE_W] <= wdata;
          cur_addr <= {wdata, base_addr[BYTE_W-1:0]};
        end
        cur_cnt <= '0;
      end else if (eng_we) begin
        cur_cnt <= eng_cnt;
      end
      if (mode_we) mode <= mode_in;
    end
  end

  always_comb begin
    rb_cnt  = base_cnt - cur_cnt;
    rb_addr = mode[MODE_DEC_BIT] ? (cur_addr - cur_cnt) : (cur_addr + cur_cnt);
  end

  // R3: high-byte write rebases the current registers
  p_hiwr_rebase_r3: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (cur_cnt == '0) && (cur_addr == base_addr));

  // R3: a low-byte write leaves current registers alone
  p_lowr_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !eng_we) |=> ($stable(cur_addr) && $stable(cur_cnt)));
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl #(
  parameter int CH_W   = 2,
  parameter int BYTE_W = 8,
  localparam int NCH   = 1 << CH_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ab_acc,
  input  logic                  wc,
  input  logic                  rc,
  input  logic [2:0]            sel,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic [NCH-1:0]        dreq,
  input  logic [NCH-1:0]        tc_set,
  input  logic [NCH*BYTE_W-1:0] mode_flat,
  output logic [BYTE_W-1:0]     ctl_rdata,
  output logic                  bptr,
  output logic [NCH-1:0]        mask,
  output logic [NCH-1:0]        req,
  output logic                  ctrl_off
);
  import dmac_pkg::*;

  logic [BYTE_W-1:0] cmd;
  logic [NCH-1:0]    tc;
  logic [CH_W-1:0]   mcnt;
  logic              mclr;
  logic              req_wr;
  logic [CH_W-1:0]   wch;

  assign mclr   = rst || (wc && sel == CW_MCLR);
  assign req_wr = wc && sel == CW_REQ;
  assign wch    = wdata[CH_W-1:0];
  assign ctrl_off = cmd[CMD_OFF_BIT];

  always_ff @(posedge clk) begin
    if (mclr) begin
      cmd <= '0;
    end else if (wc && sel == CW_CMD && (wdata & CMD_REJECT) == '0) begin
      cmd <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (mclr) begin
      mask <= '1;
    end else if (wc) begin
      case (sel)
        CW_MASK1:   mask[wch] <= wdata[CH_W];
        CW_MASKCLR: mask <= '0;
        CW_MASKALL: mask <= wdata[NCH-1:0];
        default:    mask <= mask;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mclr) begin
      req <= '0;
      tc  <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (req_wr && wch == CH_W'(i)) begin
          req[i] <= wdata[CH_W];
          tc[i]  <= 1'b0;
        end else begin
          req[i] <= dreq[i];
          if (tc_set[i])                   tc[i] <= 1'b1;
          else if (rc && sel == CR_STAT)   tc[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mclr) begin
      mcnt <= '0;
    end else if (rc && sel == CR_MODE) begin
      mcnt <= mcnt + 1'b1;
    end else if (rc && sel == CR_MCNT) begin
      mcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (mclr) begin
      bptr <= 1'b0;
    end else if (ab_acc) begin
      bptr <= ~bptr;
    end else if (wc && sel == CW_BPCLR) begin
      bptr <= 1'b0;
    end else if (rc && (sel == CR_MODE || sel == CR_BPSET)) begin
      bptr <= 1'b1;
    end
  end

  always_comb begin
    case (sel)
      CR_STAT: ctl_rdata = BYTE_W'({req, tc});
      CR_REQ:  ctl_rdata = BYTE_W'({{NCH{1'b1}}, req});
      CR_CMD:  ctl_rdata = cmd;
      CR_MODE: ctl_rdata = mode_flat[int'(mcnt)*BYTE_W +: BYTE_W] | BYTE_W'(3);
      CR_MASK: ctl_rdata = BYTE_W'(mask);
      default: ctl_rdata = '0;
    endcase
  end

  // R2: each address/count access flips the pointer
  p_bp_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    ab_acc |=> (bptr != $past(bptr)));

  // R10: void command writes leave the command untouched
  p_cmd_reject_r10: assert property (@(posedge clk) disable iff (rst)
    (wc && sel == CW_CMD && (wdata & CMD_REJECT) != '0) |=> $stable(cmd));

  // R5: a status read without new tc events leaves tc empty
  p_stat_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rc && sel == CR_STAT && tc_set == '0) |=> (tc == '0));

  // R7: without a register write the request bits track dreq
  p_req_follow_r7: assert property (@(posedge clk) disable iff (rst)
    !wc |=> (req == $past(dreq)));

  // R11: master clear state
  p_mclr_state_r11: assert property (@(posedge clk) disable iff (rst)
    (wc && sel == CW_MCLR) |=> ((&mask) && cmd == '0 && !bptr && mcnt == '0));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank #(
  parameter int WORD_MODE = 0,
  parameter int CH_W      = 2,
  parameter int BYTE_W    = 8,
  localparam int NCH      = 1 << CH_W,
  localparam int REG_W    = 2 * BYTE_W,
  localparam int OFS_W    = CH_W + 2,
  localparam int PORT_W   = OFS_W + WORD_MODE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PORT_W-1:0]     port_ofs,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [NCH-1:0]        dreq,
  input  logic [NCH-1:0]        tc_set,
  input  logic                  eng_cnt_we,
  input  logic [CH_W-1:0]       eng_cnt_ch,
  input  logic [REG_W-1:0]      eng_cnt_val,
  output logic [BYTE_W-1:0]     rd_data,
  output logic [NCH*REG_W-1:0]  base_addr_o,
  output logic [NCH*REG_W-1:0]  cur_addr_o,
  output logic [NCH*REG_W-1:0]  base_cnt_o,
  output logic [NCH*REG_W-1:0]  cur_cnt_o,
  output logic [NCH*BYTE_W-1:0] mode_o,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH-1:0]        req_o,
  output logic                  ctrl_off_o
);
  import dmac_pkg::*;

  logic [OFS_W-1:0]  ofs;
  logic              is_ctl;
  logic              is_cnt;
  logic [CH_W-1:0]   ch_sel;
  logic [2:0]        sel;
  logic              wr_act;
  logic              rd_act;
  logic              ab_acc;
  logic              bptr;
  logic [BYTE_W-1:0] ctl_rdata;
  logic [BYTE_W-1:0] rdata_n;
  logic [REG_W-1:0]  rb_addr [NCH];
  logic [REG_W-1:0]  rb_cnt  [NCH];
  logic [REG_W-1:0]  rb_word;

  assign ofs    = port_ofs[PORT_W-1:WORD_MODE];
  assign is_ctl = ofs[OFS_W-1];
  assign is_cnt = ofs[0];
  assign ch_sel = ofs[CH_W:1];
  assign sel    = ofs[2:0];
  assign wr_act = wr_en;
  assign rd_act = rd_en && !wr_en;
  assign ab_acc = (wr_act || rd_act) && !is_ctl;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic hit;
      assign hit = wr_act && !is_ctl && ch_sel == CH_W'(g);
      dmac_chan #(.BYTE_W(BYTE_W)) u_chan (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (hit && !bptr),
        .wr_hi     (hit && bptr),
        .wr_cnt    (is_cnt),
        .wdata     (wr_data),
        .mode_we   (wr_act && is_ctl && sel == CW_MODE && wr_data[CH_W-1:0] == CH_W'(g)),
        .mode_in   (wr_data),
        .eng_we    (eng_cnt_we && eng_cnt_ch == CH_W'(g)),
        .eng_cnt   (eng_cnt_val),
        .base_addr (base_addr_o[g*REG_W +: REG_W]),
        .base_cnt  (base_cnt_o[g*REG_W +: REG_W]),
        .cur_addr  (cur_addr_o[g*REG_W +: REG_W]),
        .cur_cnt   (cur_cnt_o[g*REG_W +: REG_W]),
        .mode      (mode_o[g*BYTE_W +: BYTE_W]),
        .rb_addr   (rb_addr[g]),
        .rb_cnt    (rb_cnt[g])
      );
    end
  endgenerate

  dmac_ctl #(.CH_W(CH_W), .BYTE_W(BYTE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ab_acc    (ab_acc),
    .wc        (wr_act && is_ctl),
    .rc        (rd_act && is_ctl),
    .sel       (sel),
    .wdata     (wr_data),
    .dreq      (dreq),
    .tc_set    (tc_set),
    .mode_flat (mode_o),
    .ctl_rdata (ctl_rdata),
    .bptr      (bptr),
    .mask      (mask_o),
    .req       (req_o),
    .ctrl_off  (ctrl_off_o)
  );

  always_comb begin
    rb_word = is_cnt ? rb_cnt[ch_sel] : rb_addr[ch_sel];
    if (is_ctl)    rdata_n = ctl_rdata;
    else if (bptr) rdata_n = rb_word[REG_W-1:BYTE_W];
    else           rdata_n = rb_word[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_act) rd_data <= rdata_n;
  end

  // R13: read data holds when no read is taken
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/test_dmac_regbank.sv
module test_dmac_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ofs = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdat = '0;
  logic [3:0]  dreq = '0, tc_set = '0;
  logic        eng_we = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic [15:0] eng_val = '0;
  logic [7:0]  rd_data;
  logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;
  logic [31:0] mode;
  logic [3:0]  mask, req;
  logic        ctrl_off;

  logic [4:0]  w_ofs = '0;
  logic        w_rd = 1'b0, w_wr = 1'b0;
  logic [7:0]  w_wdat = '0, w_rd_data;
  logic [63:0] w_ba, w_ca, w_bc, w_cc;
  logic [31:0] w_mode;
  logic [3:0]  w_mask, w_req;
  logic        w_off;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_regbank i_dmac_regbank (
    .clk(clk), .rst(rst), .port_ofs(ofs), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wdat),
    .dreq(dreq), .tc_set(tc_set), .eng_cnt_we(eng_we), .eng_cnt_ch(eng_ch),
    .eng_cnt_val(eng_val), .rd_data(rd_data), .base_addr_o(base_addr),
    .cur_addr_o(cur_addr), .base_cnt_o(base_cnt), .cur_cnt_o(cur_cnt), .mode_o(mode),
    .mask_o(mask), .req_o(req), .ctrl_off_o(ctrl_off));

  dmac_regbank #(.WORD_MODE(1)) i_dmac_regbank_w (
    .clk(clk), .rst(rst), .port_ofs(w_ofs), .rd_en(w_rd), .wr_en(w_wr), .wr_data(w_wdat),
    .dreq(4'b0), .tc_set(4'b0), .eng_cnt_we(1'b0), .eng_cnt_ch(2'b0),
    .eng_cnt_val(16'h0), .rd_data(w_rd_data), .base_addr_o(w_ba),
    .cur_addr_o(w_ca), .base_cnt_o(w_bc), .cur_cnt_o(w_cc), .mode_o(w_mode),
    .mask_o(w_mask), .req_o(w_req), .ctrl_off_o(w_off));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares registered read data after each taken read
  always @(posedge clk) rd_pend <= rd_en && !wr_en && !rst;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%0h expected=none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({24'h0, rd_data}, {24'h0, e}, t);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk);
    ofs = o; wdat = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] o, input logic [7:0] e, input string t);
    @(negedge clk);
    ofs = o; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(mask, 4'hF, "R1 mask port");
    chk(base_addr, 64'h0, "R1 base addr");
    rd(4'd8, 8'h00, "R1 status");
    rd(4'd10, 8'h00, "R1 command");
    rd(4'd15, 8'h0F, "R1 mask read");

    // R3 byte-pair programming of channel 1
    wr(4'd2, 8'h34); wr(4'd2, 8'h12);
    chk(base_addr[31:16], 16'h1234, "R3 base addr ch1");
    chk(cur_addr[31:16], 16'h1234, "R3 cur addr ch1");
    wr(4'd3, 8'h10); wr(4'd3, 8'h00);
    chk(base_cnt[31:16], 16'h0010, "R3 base cnt ch1");
    wr(4'd2, 8'hAA);
    chk(base_addr[31:16], 16'h12AA, "R3 low write base");
    chk(cur_addr[31:16], 16'h1234, "R3 low write keeps cur");
    wr(4'd2, 8'h12);
    chk(cur_addr[31:16], 16'h12AA, "R3 high write rebases");

    // R4 readback with engine progress
    @(negedge clk); eng_we = 1'b1; eng_ch = 2'd1; eng_val = 16'd3;
    @(negedge clk); eng_we = 1'b0;
    chk(cur_cnt[31:16], 16'd3, "R4 engine count load");
    rd(4'd3, 8'h0D, "R4 count low");
    rd(4'd3, 8'h00, "R4 count high");
    rd(4'd2, 8'hAD, "R4 inc addr low");
    rd(4'd2, 8'h12, "R4 inc addr high");
    wr(4'd11, 8'h21);
    chk(mode[15:8], 8'h21, "R9 mode write ch1");
    rd(4'd2, 8'hA7, "R4 dec addr low");
    rd(4'd2, 8'h12, "R4 dec addr high");

    // R2 byte pointer control
    wr(4'd0, 8'h55); wr(4'd12, 8'h00); wr(4'd0, 8'h66);
    chk(base_addr[15:0], 16'h0066, "R2 clear pointer");
    chk(cur_addr[15:0], 16'h0000, "R2 low only");
    wr(4'd12, 8'h00);
    rd(4'd12, 8'h00, "R13 set-pointer read value");
    wr(4'd0, 8'h77);
    chk(cur_addr[15:0], 16'h7766, "R2 set pointer read");

    // R9 mode read counter
    rd(4'd14, 8'h00, "R9 counter clear read");
    rd(4'd11, 8'h03, "R9 mode ch0");
    rd(4'd11, 8'h23, "R9 mode ch1");
    wr(4'd0, 8'h99);
    chk(base_addr[15:0], 16'h9966, "R2 mode read sets pointer");
    rd(4'd14, 8'h00, "R9 counter clear again");
    rd(4'd11, 8'h03, "R9 counter back to ch0");
    wr(4'd12, 8'h00);

    // R8 mask
    wr(4'd10, 8'h02); chk(mask, 4'hB, "R8 single clear ch2");
    wr(4'd10, 8'h00); chk(mask, 4'hA, "R8 single clear ch0");
    wr(4'd10, 8'h06); chk(mask, 4'hE, "R8 single set ch2");
    wr(4'd14, 8'h00); chk(mask, 4'h0, "R8 clear all");
    wr(4'd15, 8'hA5); chk(mask, 4'h5, "R8 load all");
    rd(4'd15, 8'h05, "R8 mask read");

    // R10 command
    wr(4'd8, 8'h04); chk(ctrl_off, 1'b1, "R10 disable bit");
    rd(4'd10, 8'h04, "R10 command read");
    wr(4'd8, 8'h14); rd(4'd10, 8'h14, "R10 accepted bits");
    wr(4'd8, 8'h01); rd(4'd10, 8'h14, "R10 reject bit0");
    wr(4'd8, 8'h80); rd(4'd10, 8'h14, "R10 reject bit7");
    wr(4'd8, 8'h00); chk(ctrl_off, 1'b0, "R10 enable");

    // R7 / R6 request levels and writes
    dreq = 4'b0101; tick(); tick();
    chk(req, 4'b0101, "R7 dreq follow");
    rd(4'd9, 8'hF5, "R6 request read");
    wr(4'd9, 8'h02); chk(req, 4'b0001, "R7 write wins clear");
    tick(); chk(req, 4'b0101, "R7 dreq resumes");
    wr(4'd9, 8'h05); chk(req, 4'b0111, "R7 write wins set");
    tick(); chk(req, 4'b0101, "R7 dreq resumes again");

    // R5 terminal count
    @(negedge clk); tc_set = 4'b1010;
    @(negedge clk); tc_set = 4'b0000;
    rd(4'd8, 8'h5A, "R5 status with tc");
    rd(4'd8, 8'h50, "R5 tc cleared");
    @(negedge clk); tc_set = 4'b0011;
    @(negedge clk); tc_set = 4'b0000;
    wr(4'd9, 8'h04);
    rd(4'd8, 8'h52, "R6 request write clears tc");
    @(negedge clk); tc_set = 4'b0100; ofs = 4'd8; rd_en = 1'b1;
    exp_q.push_back(8'h50); tag_q.push_back("R5 read during tc pulse");
    @(negedge clk); rd_en = 1'b0; tc_set = 4'b0000;
    rd(4'd8, 8'h54, "R5 tc pulse survives read");
    rd(4'd8, 8'h50, "R5 tc cleared again");

    // R11 master clear
    dreq = 4'b0000; tick();
    wr(4'd8, 8'h04); wr(4'd15, 8'h00);
    rd(4'd11, 8'h23, "R9 counter at ch1");
    wr(4'd13, 8'h00);
    chk(mask, 4'hF, "R11 mask set");
    chk(ctrl_off, 1'b0, "R11 command zero");
    wr(4'd0, 8'h22);
    chk(base_addr[15:0], 16'h9922, "R11 pointer cleared");
    chk(base_addr[31:16], 16'h12AA, "R11 base kept");
    rd(4'd11, 8'h03, "R11 counter cleared");
    rd(4'd10, 8'h00, "R11 command read");
    rd(4'd8, 8'h00, "R11 status read");
    rd(4'd13, 8'h00, "R13 temp read");
    rd(4'd15, 8'h0F, "R11 mask read");

    // R13 coincident strobes
    @(negedge clk); ofs = 4'd8; wdat = 8'h04; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk({24'h0, rd_data}, 32'h0F, "R13 read data holds");
    chk(ctrl_off, 1'b1, "R13 write taken");

    // R12 word-spaced variant
    @(negedge clk); w_ofs = 5'd17; w_wdat = 8'h14; w_wr = 1'b1;
    @(negedge clk); w_wr = 1'b0;
    chk(w_off, 1'b1, "R12 word command write");
    @(negedge clk); w_ofs = 5'd16; w_wdat = 8'h05; w_wr = 1'b1;
    @(negedge clk); w_wr = 1'b0;
    @(negedge clk); w_ofs = 5'd21; w_rd = 1'b1;
    @(negedge clk); w_rd = 1'b0;
    chk({24'h0, w_rd_data}, 32'h14, "R12 word command read");
    @(negedge clk); w_ofs = 5'd20; w_rd = 1'b1;
    @(negedge clk); w_rd = 1'b0;
    chk({24'h0, w_rd_data}, 32'h14, "R12 alias port");

    tick(); tick();
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule